// File: doc/BRIEF.md
# Nibble-Loaded Bank Mapping Controller

This block sits between an 8-bit CPU, a picture-generation bus and the memories on a plug-in cartridge. It turns CPU writes in the upper half of the address space into updates of bank-select registers, then uses those registers to turn CPU and picture-bus addresses into physical offsets and chip selects for program ROM, program RAM and character ROM. It also holds the RAM access-control setting and the nametable mirroring mode.

Each 8-bit bank number is loaded four bits at a time: one write supplies the low half, another write at the neighbouring address supplies the high half, and the half not addressed keeps its old value. Register decode looks only at the top four and the bottom two CPU address bits, so every register appears at many mirror addresses. Bank numbers wrap modulo the number of pages the ROM actually holds.

Write handling runs on a three-state machine. `ST_BOOT` is the single cycle after hard reset and accepts no write; it leaves for `ST_HOLD` if the write strobe is already high (transition "boot with strobe") or for `ST_IDLE` otherwise ("boot clear"). In `ST_IDLE` a high strobe commits the write in that cycle and moves to `ST_HOLD` ("accept"). `ST_HOLD` waits for the strobe to drop and returns to `ST_IDLE` ("release"), so one strobe assertion commits exactly once.

Top module: `bank_map_ctrl`

## Requirements
- R1: CPU reads in 0x8000–0xDFFF raise `prg_rom_cs`; addresses 0x8000–0x9FFF, 0xA000–0xBFFF and 0xC000–0xDFFF use program banks 0, 1 and 2, and `prg_rom_addr` is {bank modulo PRG_PAGES, CPU address bits 12:0}.
- R2: CPU reads in 0xE000–0xFFFF map to page PRG_PAGES-1 with the same 13-bit offset, whatever has been written.
- R3: A register write with address bit 0 clear copies data bits 3:0 into bank bits 3:0; with bit 0 set it copies data bits 3:0 into bank bits 7:4; the other half is unchanged and data bits 7:4 are never used.
- R4: Register decode uses CPU address bits 15:12 and 1:0 only; with those bits, 0x8000/0x8001 address program bank 0, 0x8002/0x8003 bank 1 and 0x9000/0x9001 bank 2.
- R5: The picture address range 0x0000–0x1FFF raises `chr_rom_cs` and is cut into eight 1 KiB windows selected by address bits 12:10; window n uses character bank n, loaded at 0xA000/1, 0xA002/3, 0xB000/1, 0xB002/3, 0xC000/1, 0xC002/3, 0xD000/1, 0xD002/3 for n = 0..7, and `chr_rom_addr` is {bank modulo CHR_PAGES, picture address bits 9:0}.
- R6: A write at 0x9002 sets RAM access from data bits 1:0: bit 0 clear gives no access, bit 0 set with bit 1 clear gives read only, both set give read-write; a CPU read in 0x6000–0x7FFF raises `ram_cs` only when access is not off, with `ram_addr` equal to CPU address bits 12:0.
- R7: A CPU write in 0x6000–0x7FFF raises `ram_cs` and `ram_we` only in read-write mode; otherwise both stay low.
- R8: A write at 0xF002 sets `mirror_mode` to data bits 1:0 (0 horizontal, 1 vertical, 2 single screen A, 3 single screen B); it changes at no other time except reset.
- R9: Writes to decoded addresses with no register (0x9003, 0xE000–0xE003, 0xF000, 0xF001, 0xF003 and their mirrors) change no bank, access or mirroring state.
- R10: A write strobe held high for several cycles commits once, with the address and data present in its first cycle.
- R11: Hard reset (`rst_n` low) clears every bank register to 0, RAM access to off and mirroring to 0; the first clock edge after release commits no write, and a strobe already high then is ignored until it drops.
- R12: A cycle with `soft_rst` high clears RAM access and mirroring, leaves the bank registers unchanged, and commits no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of control settings |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| vid_addr | input | 14 | Picture-bus address |
| prg_rom_addr | output | $clog2(PRG_PAGES)+13 | Program ROM byte offset |
| prg_rom_cs | output | 1 | Program ROM select |
| ram_addr | output | 13 | Program RAM byte offset |
| ram_cs | output | 1 | Program RAM select |
| ram_we | output | 1 | Program RAM write enable |
| chr_rom_addr | output | $clog2(CHR_PAGES)+10 | Character ROM byte offset |
| chr_rom_cs | output | 1 | Character ROM select |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The hardest case to reach is a write strobe that is already high when hard reset is released, because it must cross the boot cycle and the hold state without committing. The bench raises the strobe with a mirroring write while `rst_n` is low, releases reset under it, holds it two more edges and then checks that mirroring and the cleared banks are untouched. A held strobe whose data changes mid-assertion is driven the same way to show that only the first cycle's data lands.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int NUM_PRG_SW  = 3;
    localparam int NUM_CHR_SW  = 8;
    localparam int PRG_OFF_W   = 13;
    localparam int CHR_OFF_W   = 10;

    typedef enum logic [1:0] {
        MIR_HORZ  = 2'd0,
        MIR_VERT  = 2'd1,
        MIR_ONE_A = 2'd2,
        MIR_ONE_B = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        RAM_OFF = 2'd0,
        RAM_RD  = 2'd1,
        RAM_RW  = 2'd2
    } ram_acc_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_IDLE = 2'd1,
        ST_HOLD = 2'd2
    } wr_state_e;

    typedef enum logic [2:0] {
        REG_NONE   = 3'd0,
        REG_PRG    = 3'd1,
        REG_CHR    = 3'd2,
        REG_RAMACC = 3'd3,
        REG_MIRROR = 3'd4
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [2:0] idx;
        logic       hi;
    } reg_sel_t;

    // key = {addr[15:12], addr[1:0]}
    function automatic reg_sel_t decode_key(input logic [5:0] key);
        reg_sel_t   s;
        logic [3:0] pg;
        pg     = key[5:2];
        s.kind = REG_NONE;
        s.idx  = 3'd0;
        s.hi   = key[0];
        case (pg)
            4'h8: begin
                s.kind = REG_PRG;
                s.idx  = {2'b00, key[1]};
            end
            4'h9: begin
                if (!key[1]) begin
                    s.kind = REG_PRG;
                    s.idx  = 3'd2;
                end else if (!key[0]) begin
                    s.kind = REG_RAMACC;
                end
            end
            4'hA, 4'hB, 4'hC, 4'hD: begin
                s.kind = REG_CHR;
                s.idx  = 3'({pg[2:0] - 3'd2, key[1]});
            end
            4'hF: begin
                if (key[1:0] == 2'b10) s.kind = REG_MIRROR;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bmc_wr_fsm.sv
module bmc_wr_fsm
    import bmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_wr,
    output logic commit
);

    wr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = cpu_wr ? ST_HOLD : ST_IDLE;
            ST_IDLE: if (cpu_wr)  state_d = ST_HOLD;
            ST_HOLD: if (!cpu_wr) state_d = ST_IDLE;
            default: state_d = ST_BOOT;
        endcase
    end

    always_comb begin
        commit = (state_q == ST_IDLE) && cpu_wr;
    end

    assert_single_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_hold_while_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cpu_wr) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/bmc_regs.sv
module bmc_regs
    import bmc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             soft_rst,
    input  logic                             commit,
    input  logic [5:0]                       reg_key,
    input  logic [3:0]                       nib,
    output logic [NUM_PRG_SW-1:0][7:0]       prg_bank,
    output logic [NUM_CHR_SW-1:0][7:0]       chr_bank,
    output ram_acc_e                         ram_acc,
    output mirror_e                          mirror
);

    reg_sel_t sel;
    logic     wr_ok;

    always_comb begin
        sel   = decode_key(reg_key);
        wr_ok = commit && !soft_rst;
    end

    for (genvar g = 0; g < NUM_PRG_SW; g++) begin : g_prg
        logic [7:0] bank_q;
        logic       hit;
        assign hit = wr_ok && (sel.kind == REG_PRG) && (sel.idx == 3'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= 8'd0;
            end else if (hit) begin
                if (sel.hi) bank_q[7:4] <= nib;
                else        bank_q[3:0] <= nib;
            end
        end
        assign prg_bank[g] = bank_q;

        assert_prg_keep_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !sel.hi) |=> (prg_bank[g][7:4] == $past(prg_bank[g][7:4])));
        assert_prg_keep_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && sel.hi) |=> (prg_bank[g][3:0] == $past(prg_bank[g][3:0])));
        assert_prg_soft_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> $stable(prg_bank[g]));
    end

    for (genvar g = 0; g < NUM_CHR_SW; g++) begin : g_chr
        logic [7:0] bank_q;
        logic       hit;
        assign hit = wr_ok && (sel.kind == REG_CHR) && (sel.idx == 3'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q <= 8'd0;
            end else if (hit) begin
                if (sel.hi) bank_q[7:4] <= nib;
                else        bank_q[3:0] <= nib;
            end
        end
        assign chr_bank[g] = bank_q;

        assert_chr_keep_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !sel.hi) |=> (chr_bank[g][7:4] == $past(chr_bank[g][7:4])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_acc <= RAM_OFF;
            mirror  <= MIR_HORZ;
        end else if (soft_rst) begin
            ram_acc <= RAM_OFF;
            mirror  <= MIR_HORZ;
        end else if (commit) begin
            if (sel.kind == REG_RAMACC)
                ram_acc <= !nib[0] ? RAM_OFF : (nib[1] ? RAM_RW : RAM_RD);
            if (sel.kind == REG_MIRROR)
                mirror <= mirror_e'(nib[1:0]);
        end
    end

    assert_soft_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ram_acc == RAM_OFF && mirror == MIR_HORZ));

    assert_mirror_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(commit && sel.kind == REG_MIRROR)) |=> $stable(mirror));

endmodule

// File: rtl/bmc_xlate.sv
module bmc_xlate
    import bmc_pkg::*;
#(
    parameter int PRG_PAGES = 32,
    parameter int CHR_PAGES = 128,
    localparam int PRG_PW   = $clog2(PRG_PAGES),
    localparam int CHR_PW   = $clog2(CHR_PAGES),
    localparam int PRG_AW   = PRG_PW + PRG_OFF_W,
    localparam int CHR_AW   = CHR_PW + CHR_OFF_W
)(
    input  logic [15:0]                  cpu_addr,
    input  logic                         cpu_rd,
    input  logic                         cpu_wr,
    input  logic [13:0]                  vid_addr,
    input  logic [NUM_PRG_SW-1:0][7:0]   prg_bank,
    input  logic [NUM_CHR_SW-1:0][7:0]   chr_bank,
    input  ram_acc_e                     ram_acc,
    output logic [PRG_AW-1:0]            prg_rom_addr,
    output logic                         prg_rom_cs,
    output logic [PRG_OFF_W-1:0]         ram_addr,
    output logic                         ram_cs,
    output logic                         ram_we,
    output logic [CHR_AW-1:0]            chr_rom_addr,
    output logic                         chr_rom_cs
);

    localparam int FIX_PAGE = PRG_PAGES - 1;

    logic [7:0] win_bank;
    logic [8:0] prg_fold;
    logic [7:0] chr_sel;
    logic [8:0] chr_fold;
    logic       in_ram;

    always_comb begin
        unique case (cpu_addr[14:13])
            2'd0:    win_bank = prg_bank[0];
            2'd1:    win_bank = prg_bank[1];
            2'd2:    win_bank = prg_bank[2];
            default: win_bank = 8'(FIX_PAGE);
        endcase
        prg_fold     = {1'b0, win_bank} % 9'(PRG_PAGES);
        prg_rom_addr = {PRG_PW'(prg_fold), cpu_addr[PRG_OFF_W-1:0]};
        prg_rom_cs   = cpu_addr[15] && cpu_rd;
    end

    always_comb begin
        in_ram   = (cpu_addr[15:13] == 3'b011);
        ram_addr = cpu_addr[PRG_OFF_W-1:0];
        ram_we   = in_ram && cpu_wr && (ram_acc == RAM_RW);
        ram_cs   = in_ram && ((cpu_rd && ram_acc != RAM_OFF) ||
                              (cpu_wr && ram_acc == RAM_RW));
    end

    always_comb begin
        chr_sel      = chr_bank[vid_addr[12:10]];
        chr_fold     = {1'b0, chr_sel} % 9'(CHR_PAGES);
        chr_rom_addr = {CHR_PW'(chr_fold), vid_addr[CHR_OFF_W-1:0]};
        chr_rom_cs   = !vid_addr[13];
    end

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bmc_pkg::*;
#(
    parameter int PRG_PAGES = 32,
    parameter int CHR_PAGES = 128,
    localparam int PRG_AW   = $clog2(PRG_PAGES) + PRG_OFF_W,
    localparam int CHR_AW   = $clog2(CHR_PAGES) + CHR_OFF_W
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic [13:0]          vid_addr,
    output logic [PRG_AW-1:0]    prg_rom_addr,
    output logic                 prg_rom_cs,
    output logic [PRG_OFF_W-1:0] ram_addr,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic [CHR_AW-1:0]    chr_rom_addr,
    output logic                 chr_rom_cs,
    output logic [1:0]           mirror_mode
);

    logic                       commit;
    logic [NUM_PRG_SW-1:0][7:0] prg_bank;
    logic [NUM_CHR_SW-1:0][7:0] chr_bank;
    ram_acc_e                   ram_acc;
    mirror_e                    mirror;
    logic                       unused_data_hi;

    assign unused_data_hi = ^cpu_data[7:4];

    bmc_wr_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_wr (cpu_wr),
        .commit (commit)
    );

    bmc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .commit   (commit),
        .reg_key  ({cpu_addr[15:12], cpu_addr[1:0]}),
        .nib      (cpu_data[3:0]),
        .prg_bank (prg_bank),
        .chr_bank (chr_bank),
        .ram_acc  (ram_acc),
        .mirror   (mirror)
    );

    bmc_xlate #(
        .PRG_PAGES (PRG_PAGES),
        .CHR_PAGES (CHR_PAGES)
    ) u_xlate (
        .cpu_addr     (cpu_addr),
        .cpu_rd       (cpu_rd),
        .cpu_wr       (cpu_wr),
        .vid_addr     (vid_addr),
        .prg_bank     (prg_bank),
        .chr_bank     (chr_bank),
        .ram_acc      (ram_acc),
        .prg_rom_addr (prg_rom_addr),
        .prg_rom_cs   (prg_rom_cs),
        .ram_addr     (ram_addr),
        .ram_cs       (ram_cs),
        .ram_we       (ram_we),
        .chr_rom_addr (chr_rom_addr),
        .chr_rom_cs   (chr_rom_cs)
    );

    assign mirror_mode = mirror;

    assert_ram_write_needs_rw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_acc == RAM_RW));

    assert_rom_ram_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_rom_cs && ram_cs));

    assert_ram_off_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_acc == RAM_OFF) |-> !ram_cs);

endmodule

// File: tb/bank_map_ctrl_test.sv
`timescale 1ns/1ps
module bank_map_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_data = 8'h0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [13:0] vid_addr = 14'h0;
    logic [17:0] prg_rom_addr;
    logic        prg_rom_cs;
    logic [12:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [16:0] chr_rom_addr;
    logic        chr_rom_cs;
    logic [1:0]  mirror_mode;

    int n_checks = 0;
    int n_fail   = 0;
    logic        seen_we, seen_cs;
    logic [12:0] seen_raddr;

    always #2 clk = ~clk;

    bank_map_ctrl #(.PRG_PAGES(32), .CHR_PAGES(128)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .vid_addr(vid_addr),
        .prg_rom_addr(prg_rom_addr), .prg_rom_cs(prg_rom_cs),
        .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .chr_rom_addr(chr_rom_addr), .chr_rom_cs(chr_rom_cs),
        .mirror_mode(mirror_mode)
    );

    // {write addr, write data, read addr, expected program offset}
    localparam logic [63:0] VEC [11] = '{
        {16'h8000, 8'h05, 16'h8000, 24'h00A000},
        {16'h8001, 8'h01, 16'h8123, 24'h02A123},
        {16'h8003, 8'h0F, 16'hA010, 24'h020010},
        {16'h8002, 8'h07, 16'hBFFF, 24'h02FFFF},
        {16'h9000, 8'h03, 16'hC000, 24'h006000},
        {16'h9001, 8'h02, 16'hDFFF, 24'h007FFF},
        {16'h8FF0, 8'h09, 16'h8000, 24'h032000},
        {16'h8FF1, 8'hE2, 16'h9ABC, 24'h013ABC},
        {16'h8000, 8'h00, 16'hE000, 24'h03E000},
        {16'h9003, 8'hFF, 16'hFFFF, 24'h03FFFF},
        {16'hE000, 8'h55, 16'h8000, 24'h000000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        #1;
        seen_we = ram_we; seen_cs = ram_cs; seen_raddr = ram_addr;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [15:0] a);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = a; cpu_rd = 1'b1;
        #1;
    endtask

    task automatic vid_read(input logic [13:0] a);
        @(negedge clk);
        vid_addr = a;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        check("R11 mirror after reset", 32'(mirror_mode), 32'd0);
        cpu_read(16'h6000);
        check("R11 ram off after reset", 32'(ram_cs), 32'd0);
        cpu_read(16'h8000);
        check("R11 prg bank0 zero", 32'(prg_rom_addr), 32'h0);
        check("R1 prg cs on read", 32'(prg_rom_cs), 32'd1);
        cpu_read(16'hE000);
        check("R2 fixed window", 32'(prg_rom_addr), 32'h3E000);
        vid_read(14'h0400);
        check("R11 chr bank1 zero", 32'(chr_rom_addr), 32'h0);

        // vector walk: R1 R3 R4 R2 R9
        for (int i = 0; i < 11; i++) begin
            cpu_write(VEC[i][63:48], VEC[i][47:40]);
            cpu_read(VEC[i][39:24]);
            check($sformatf("R1 R3 R4 vector %0d", i), 32'(prg_rom_addr), 32'(VEC[i][23:0]));
        end

        // character windows R5
        cpu_write(16'hA002, 8'h05);
        cpu_write(16'hA003, 8'h01);
        vid_read(14'h07FF);
        check("R5 chr bank1", 32'(chr_rom_addr), 32'h57FF);
        check("R5 chr cs", 32'(chr_rom_cs), 32'd1);
        cpu_write(16'hD003, 8'h0F);
        cpu_write(16'hD002, 8'h0A);
        vid_read(14'h1C05);
        check("R5 chr bank7 modulo", 32'(chr_rom_addr), 32'h1E805);
        vid_read(14'h2000);
        check("R5 chr cs off above 0x1FFF", 32'(chr_rom_cs), 32'd0);

        // RAM access R6 R7
        cpu_write(16'h9002, 8'h01);
        cpu_read(16'h6000);
        check("R6 read-only read select", 32'(ram_cs), 32'd1);
        check("R6 ram addr", 32'(ram_addr), 32'h0);
        cpu_write(16'h6ABC, 8'h77);
        check("R7 read-only write we", 32'(seen_we), 32'd0);
        check("R7 read-only write cs", 32'(seen_cs), 32'd0);
        cpu_write(16'h9002, 8'h03);
        cpu_write(16'h7FFF, 8'h11);
        check("R7 rw write we", 32'(seen_we), 32'd1);
        check("R7 rw write cs", 32'(seen_cs), 32'd1);
        check("R7 rw write addr", 32'(seen_raddr), 32'h1FFF);
        cpu_write(16'h9002, 8'h02);
        cpu_read(16'h6000);
        check("R6 bit0 clear disables", 32'(ram_cs), 32'd0);
        cpu_write(16'h9002, 8'hF1);
        cpu_read(16'h7123);
        check("R6 upper data bits ignored", 32'(ram_cs), 32'd1);
        cpu_write(16'h7123, 8'h00);
        check("R7 read-only via F1 no we", 32'(seen_we), 32'd0);
        cpu_write(16'h9002, 8'h03);

        // mirroring R8
        cpu_write(16'hF002, 8'h06);
        check("R8 mirror single A", 32'(mirror_mode), 32'd2);
        cpu_write(16'hF002, 8'hFD);
        check("R8 mirror vertical", 32'(mirror_mode), 32'd1);
        cpu_write(16'hFFF2, 8'h03);
        check("R8 mirror single B via mirror addr", 32'(mirror_mode), 32'd3);

        // ignored addresses R9
        cpu_write(16'hF003, 8'h01);
        cpu_write(16'hF000, 8'hFF);
        cpu_write(16'hF001, 8'hFF);
        cpu_write(16'hE002, 8'h5A);
        cpu_write(16'h9003, 8'hFF);
        check("R9 mirror unchanged", 32'(mirror_mode), 32'd3);
        cpu_read(16'hA000);
        check("R9 prg bank1 unchanged", 32'(prg_rom_addr), 32'h2E000);
        cpu_read(16'hC000);
        check("R9 prg bank2 unchanged", 32'(prg_rom_addr), 32'h6000);
        cpu_write(16'h7000, 8'h11);
        check("R9 ram access unchanged", 32'(seen_we), 32'd1);

        // held strobe R10
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h8000; cpu_data = 8'h01; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_data = 8'h02;
        @(negedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
        cpu_read(16'h8000);
        check("R10 single commit first data", 32'(prg_rom_addr), 32'h2000);

        // soft reset R12
        @(negedge clk);
        cpu_rd = 1'b0;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R12 mirror cleared", 32'(mirror_mode), 32'd0);
        cpu_read(16'h6000);
        check("R12 ram access cleared", 32'(ram_cs), 32'd0);
        cpu_read(16'h8000);
        check("R12 banks kept", 32'(prg_rom_addr), 32'h2000);
        vid_read(14'h1C05);
        check("R12 chr banks kept", 32'(chr_rom_addr), 32'h1E805);

        // strobe across hard reset release R11
        @(negedge clk);
        cpu_rd = 1'b0;
        rst_n = 1'b0;
        cpu_addr = 16'hF002; cpu_data = 8'h01; cpu_wr = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cpu_wr = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 boot write ignored", 32'(mirror_mode), 32'd0);
        cpu_read(16'h8000);
        check("R11 hard reset clears prg", 32'(prg_rom_addr), 32'h0);
        vid_read(14'h1C05);
        check("R11 hard reset clears chr", 32'(chr_rom_addr), 32'h5);
        cpu_read(16'hFFFF);
        check("R2 fixed window after hard reset", 32'(prg_rom_addr), 32'h3FFFF);
        cpu_write(16'hF002, 8'h01);
        check("R11 writes accepted after boot", 32'(mirror_mode), 32'd1);

        finish_run();
    end

endmodule